// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the register front end of a compact interrupt controller serving up to 32 interrupt sources and 2 target contexts. A host issues 32-bit word reads and writes on a simple request bus (valid, write, address, write data). Each accepted access is answered one cycle later with a single ready pulse, together with read data for reads. The address space has three regions. The first holds one priority register per source. The second holds one set of enable words per context. The third holds, for each context, a threshold register and a claim/complete register.

The block stores the priority and enable arrays itself. It does not store threshold or claim state. For those it reads data from the per-context claim arbiters that sit beside it, and it sends them one-cycle strobes along with the write data. When a host write changes enable bits, the block issues pending-set and pending-clear pulses to the arbiters. A pending set depends on the live source level in the cycle of the write. The arbiters capture the source priority from the priority outputs when they see the set pulse.

Top module: `pic_reg_frontend`

## Requirements
- R1: A write to byte offset 4·N, for source N with 1 ≤ N < NUM_SRC, stores the low 4 bits of the write data as that source's priority. It appears on `prio_o[N*4 +: 4]` in the ready cycle. A read returns it zero-extended to 32 bits.
- R2: The priority slot of source 0 (offset 0), and every slot with N ≥ NUM_SRC, ignores writes and reads as 0. `prio_o[3:0]` is always 0.
- R3: The enable words of context c start at 0x2000 + 0x80·c. Bit b of word w enables source 32·w + b, and the enable bits are visible on `enable_o[c*NUM_SRC +: NUM_SRC]`. A read of an enable word returns the stored bits.
- R4: The enable bit of source 0 in every context is forced to 0 on write and always reads as 0.
- R5: An enable write that takes bit s from 0 to 1 while `src_level[s]` is high in the accepting cycle raises `pend_set` for that context and source for exactly the ready cycle. If the level is low, no set pulse is produced.
- R6: An enable write that takes bit s from 1 to 0 raises `pend_clr` for that context and source for exactly the ready cycle. Bits the write leaves unchanged produce no set or clear pulse.
- R7: The control block of context c starts at 0x200000 + 0x1000·c. A write to offset 0 of that block pulses `thr_wr[c]` with the bus data on `ctx_wdata`. A read of offset 0 returns that context's `arb_thresh` value, zero-extended.
- R8: A read of offset 4 in the control block returns that context's `arb_claim_id`, zero-extended, and pulses `claim_rd[c]`. A write to offset 4 pulses `complete_wr[c]` with the bus data on `ctx_wdata`. At most one context strobe is high in any cycle.
- R9: An access that names a context number at or above NUM_CTX, in either the enable region or the control region, changes nothing, raises no strobe and reads as 0.
- R10: Reads of reserved locations (enable words past the last source, control offsets other than 0 and 4, addresses at or above 0x1000000) return 0. Writes to them have no effect.
- R11: Address bits [1:0] are ignored for both reads and writes.
- R12: After reset, `bus_ready`, every priority, every enable bit and every strobe are 0. An access is accepted when `bus_valid` is high and `bus_ready` is low, and it gets exactly one ready pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (24) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle completion pulse |
| src_level | input | NUM_SRC | Live source levels |
| prio_o | output | NUM_SRC*4 | Stored priorities, 4 bits per source |
| enable_o | output | NUM_CTX*NUM_SRC | Stored enable bits per context |
| pend_set | output | NUM_CTX*NUM_SRC | Pending-set pulses |
| pend_clr | output | NUM_CTX*NUM_SRC | Pending/claimed clear pulses |
| thr_wr | output | NUM_CTX | Threshold write strobe per context |
| claim_rd | output | NUM_CTX | Claim read strobe per context |
| complete_wr | output | NUM_CTX | Completion write strobe per context |
| ctx_wdata | output | 32 | Write data accompanying context strobes |
| arb_thresh | input | NUM_CTX*4 | Threshold value from each arbiter |
| arb_claim_id | input | NUM_CTX*ID_W | Best-candidate ID from each arbiter |

## Verification
One enable write can raise an enable bit and lower another in the same word, so a pending-set and a pending-clear pulse fall in the same ready cycle. The bench drives a single write to a context that turns some enabled sources off and turns others on. Some of the newly enabled sources have their level high and some have it low, while a source that was already enabled with its level high is left unchanged. Both pulse vectors are then compared, bit for bit, with the rising-and-high and falling masks computed in the bench, and the untouched context must show no pulse at all.

// File: rtl/pic_regs_pkg.sv
// Package pic_regs_pkg
// Purpose : region bases, strides and the decoded-access record shared by the
//           interrupt controller register front end.
// Assumes : addresses are byte addresses and at most 32 bits wide.
package pic_regs_pkg;

    localparam int unsigned EN_BASE    = 32'h0000_2000;
    localparam int unsigned EN_SHIFT   = 7;             // 0x80 bytes per context
    localparam int unsigned CTX_BASE   = 32'h0020_0000;
    localparam int unsigned CTX_SHIFT  = 12;            // 0x1000 bytes per context
    localparam int unsigned SPACE_TOP  = 32'h0100_0000;
    localparam int unsigned REG_THRESH = 0;             // word index in control block
    localparam int unsigned REG_CLAIM  = 1;

    typedef struct packed {
        logic        prio_hit;
        logic        en_hit;
        logic        thr_hit;
        logic        claim_hit;
        logic [31:0] src;
        logic [31:0] word;
        logic [31:0] ctx;
    } pic_dec_t;

endpackage

// File: rtl/pic_addr_decode.sv
// Module pic_addr_decode
// Purpose : splits a byte address into region hits and indices.
// Assumes : purely combinational; the low two address bits are discarded;
//           every hit flag already excludes reserved and out-of-range targets.
module pic_addr_decode #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    parameter int ADDR_W  = 24
) (
    input  logic [ADDR_W-1:0]          addr,
    output pic_regs_pkg::pic_dec_t     dec
);
    import pic_regs_pkg::*;

    localparam int NUM_WORDS = (NUM_SRC + 31) / 32;

    logic [31:0] a_word;
    logic [31:0] en_off;
    logic [31:0] cb_off;
    logic [31:0] en_ctx;
    logic [31:0] cb_ctx;
    logic [31:0] cb_reg;
    logic        in_prio;
    logic        in_en;
    logic        in_cb;

    // Align the address and compute region-relative offsets.
    always_comb begin
        a_word  = 32'(addr) & ~32'h3;
        en_off  = a_word - EN_BASE;
        cb_off  = a_word - CTX_BASE;
        en_ctx  = en_off >> EN_SHIFT;
        cb_ctx  = cb_off >> CTX_SHIFT;
        cb_reg  = (cb_off >> 2) & 32'h3FF;
        in_prio = a_word < EN_BASE;
        in_en   = (a_word >= EN_BASE) && (a_word < CTX_BASE);
        in_cb   = (a_word >= CTX_BASE) && (a_word < SPACE_TOP);
    end

    // Produce hit flags and indices for the banks.
    always_comb begin
        dec.src       = a_word >> 2;
        dec.word      = (en_off >> 2) & 32'h1F;
        dec.ctx       = in_en ? en_ctx : cb_ctx;
        dec.prio_hit  = in_prio && (dec.src != 32'd0) && (dec.src < 32'(NUM_SRC));
        dec.en_hit    = in_en && (en_ctx < 32'(NUM_CTX)) && (dec.word < 32'(NUM_WORDS));
        dec.thr_hit   = in_cb && (cb_ctx < 32'(NUM_CTX)) && (cb_reg == REG_THRESH);
        dec.claim_hit = in_cb && (cb_ctx < 32'(NUM_CTX)) && (cb_reg == REG_CLAIM);
    end

endmodule

// File: rtl/pic_prio_bank.sv
// Module pic_prio_bank
// Purpose : holds the per-source priority registers and serves reads.
// Assumes : source 0 has no storage and reads as zero; NUM_SRC >= 2.
module pic_prio_bank #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [31:0]                 idx,
    input  logic [PRIO_W-1:0]           wdata,
    output logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    output logic [PRIO_W-1:0]           rd_prio
);
    logic [PRIO_W-1:0] prio_q [1:NUM_SRC-1];

    // Store the priority of the addressed source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 1; s < NUM_SRC; s++) prio_q[s] <= '0;
        end else if (we) begin
            for (int s = 1; s < NUM_SRC; s++)
                if (idx == 32'(s)) prio_q[s] <= wdata;
        end
    end

    // Flatten the array for the arbiters; slot 0 is tied low.
    assign prio_flat[PRIO_W-1:0] = '0;
    for (genvar g = 1; g < NUM_SRC; g++) begin : g_flat
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
    end

    // Select the addressed priority for a read.
    always_comb begin
        rd_prio = '0;
        for (int s = 1; s < NUM_SRC; s++)
            if (idx == 32'(s)) rd_prio = prio_q[s];
    end

endmodule

// File: rtl/pic_enable_bank.sv
// Module pic_enable_bank
// Purpose : holds each context's enable bits and turns enable changes into
//           one-cycle pending-set and pending-clear pulses.
// Assumes : a set pulse uses the source level of the accepting cycle; the
//           source 0 enable bit is never stored as 1.
module pic_enable_bank #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [31:0]                 ctx,
    input  logic [31:0]                 word,
    input  logic [31:0]                 wdata,
    input  logic [NUM_SRC-1:0]          level,
    output logic [NUM_CTX*NUM_SRC-1:0]  en_flat,
    output logic [NUM_CTX*NUM_SRC-1:0]  set_flat,
    output logic [NUM_CTX*NUM_SRC-1:0]  clr_flat,
    output logic [31:0]                 rd_word
);
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        logic [NUM_SRC-1:0] en_q;
        logic [NUM_SRC-1:0] en_nx;
        logic [NUM_SRC-1:0] set_q;
        logic [NUM_SRC-1:0] clr_q;
        logic               hit;

        assign hit = we && (ctx == 32'(c));

        // Merge the written word into this context's enable vector.
        always_comb begin
            en_nx = en_q;
            for (int s = 0; s < NUM_SRC; s++)
                if (word == 32'(s / 32)) en_nx[s] = wdata[s % 32];
            en_nx[0] = 1'b0;
        end

        // Update enables and emit edge-derived pending pulses.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q  <= '0;
                set_q <= '0;
                clr_q <= '0;
            end else begin
                set_q <= '0;
                clr_q <= '0;
                if (hit) begin
                    en_q  <= en_nx;
                    set_q <= en_nx & ~en_q & level;
                    clr_q <= en_q & ~en_nx;
                end
            end
        end

        assign en_flat [c*NUM_SRC +: NUM_SRC] = en_q;
        assign set_flat[c*NUM_SRC +: NUM_SRC] = set_q;
        assign clr_flat[c*NUM_SRC +: NUM_SRC] = clr_q;
    end

    // Select the addressed enable word for a read.
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CTX; c++)
            for (int s = 0; s < NUM_SRC; s++)
                if ((ctx == 32'(c)) && (word == 32'(s / 32)))
                    rd_word[s % 32] = en_flat[c*NUM_SRC + s];
    end

endmodule

// File: rtl/pic_reg_frontend.sv
// Module pic_reg_frontend
// Purpose : register front end of the interrupt controller. Accepts word
//           accesses, owns priorities and enables, and strobes the per-context
//           claim arbiters for threshold and claim/complete traffic.
// Assumes : one access is outstanding at a time; an access is taken when
//           bus_valid is high and bus_ready is low; answers one cycle later.
module pic_reg_frontend #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 24,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_ready,
    input  logic [NUM_SRC-1:0]          src_level,
    output logic [NUM_SRC*PRIO_W-1:0]   prio_o,
    output logic [NUM_CTX*NUM_SRC-1:0]  enable_o,
    output logic [NUM_CTX*NUM_SRC-1:0]  pend_set,
    output logic [NUM_CTX*NUM_SRC-1:0]  pend_clr,
    output logic [NUM_CTX-1:0]          thr_wr,
    output logic [NUM_CTX-1:0]          claim_rd,
    output logic [NUM_CTX-1:0]          complete_wr,
    output logic [31:0]                 ctx_wdata,
    input  logic [NUM_CTX*PRIO_W-1:0]   arb_thresh,
    input  logic [NUM_CTX*ID_W-1:0]     arb_claim_id
);
    import pic_regs_pkg::*;

    pic_dec_t           dec;
    logic               accept;
    logic               wr_acc;
    logic               rd_acc;
    logic [PRIO_W-1:0]  prio_rd;
    logic [31:0]        en_rd;
    logic [31:0]        rd_nx;

    assign accept = bus_valid && !bus_ready;
    assign wr_acc = accept && bus_write;
    assign rd_acc = accept && !bus_write;

    pic_addr_decode #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .ADDR_W  (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    pic_prio_bank #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_acc && dec.prio_hit),
        .idx       (dec.src),
        .wdata     (bus_wdata[PRIO_W-1:0]),
        .prio_flat (prio_o),
        .rd_prio   (prio_rd)
    );

    pic_enable_bank #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX)
    ) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_acc && dec.en_hit),
        .ctx      (dec.ctx),
        .word     (dec.word),
        .wdata    (bus_wdata),
        .level    (src_level),
        .en_flat  (enable_o),
        .set_flat (pend_set),
        .clr_flat (pend_clr),
        .rd_word  (en_rd)
    );

    // Choose the read data for the accepted address.
    always_comb begin
        rd_nx = '0;
        if (dec.prio_hit) begin
            rd_nx = 32'(prio_rd);
        end else if (dec.en_hit) begin
            rd_nx = en_rd;
        end else if (dec.thr_hit) begin
            for (int c = 0; c < NUM_CTX; c++)
                if (dec.ctx == 32'(c)) rd_nx = 32'(arb_thresh[c*PRIO_W +: PRIO_W]);
        end else if (dec.claim_hit) begin
            for (int c = 0; c < NUM_CTX; c++)
                if (dec.ctx == 32'(c)) rd_nx = 32'(arb_claim_id[c*ID_W +: ID_W]);
        end
    end

    // Register completion, read data and the per-context strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready   <= 1'b0;
            bus_rdata   <= '0;
            thr_wr      <= '0;
            claim_rd    <= '0;
            complete_wr <= '0;
            ctx_wdata   <= '0;
        end else begin
            bus_ready <= accept;
            bus_rdata <= rd_acc ? rd_nx : '0;
            if (wr_acc) ctx_wdata <= bus_wdata;
            for (int c = 0; c < NUM_CTX; c++) begin
                thr_wr[c]      <= wr_acc && dec.thr_hit   && (dec.ctx == 32'(c));
                claim_rd[c]    <= rd_acc && dec.claim_hit && (dec.ctx == 32'(c));
                complete_wr[c] <= wr_acc && dec.claim_hit && (dec.ctx == 32'(c));
            end
        end
    end

endmodule

// File: rtl/pic_reg_frontend_chk.sv
// Module pic_reg_frontend_chk
// Purpose : protocol and state assertions for pic_reg_frontend, bound below.
// Assumes : observes ports only.
module pic_reg_frontend_chk #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_valid,
    input logic                        bus_write,
    input logic                        bus_ready,
    input logic [NUM_SRC*PRIO_W-1:0]   prio_o,
    input logic [NUM_CTX*NUM_SRC-1:0]  enable_o,
    input logic [NUM_CTX*NUM_SRC-1:0]  pend_set,
    input logic [NUM_CTX*NUM_SRC-1:0]  pend_clr,
    input logic [NUM_CTX-1:0]          thr_wr,
    input logic [NUM_CTX-1:0]          claim_rd,
    input logic [NUM_CTX-1:0]          complete_wr
);
    // R12: every accepted access is answered on the next cycle
    assert_ready_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> bus_ready);

    // R12: ready is a single-cycle pulse
    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R1: priorities change only after an accepted write
    assert_prio_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_ready && bus_write) |=> $stable(prio_o));

    // R2: source 0 priority slot stays zero
    assert_prio0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prio_o[PRIO_W-1:0] == '0);

    // R3: enables change only after an accepted write
    assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_ready && bus_write) |=> $stable(enable_o));

    // R5: a set pulse only for a source that is now enabled
    assert_set_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set & ~enable_o) == '0);

    // R6: a clear pulse only for a source that is now disabled
    assert_clr_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr & enable_o) == '0);

    // R7: context strobes and pending pulses appear only with ready
    assert_strobe_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|{thr_wr, claim_rd, complete_wr, pend_set, pend_clr}) |-> bus_ready);

    // R8: at most one context strobe per cycle
    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({thr_wr, claim_rd, complete_wr}));

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_bit0
        // R4: source 0 is never enabled
        assert_en_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !enable_o[c*NUM_SRC]);
    end

endmodule

bind pic_reg_frontend pic_reg_frontend_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_W  (PRIO_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_ready   (bus_ready),
    .prio_o      (prio_o),
    .enable_o    (enable_o),
    .pend_set    (pend_set),
    .pend_clr    (pend_clr),
    .thr_wr      (thr_wr),
    .claim_rd    (claim_rd),
    .complete_wr (complete_wr)
);

// File: tb/pic_reg_frontend_tb.sv
module pic_reg_frontend_tb;
    localparam int NUM_SRC = 32;
    localparam int NUM_CTX = 2;
    localparam int PRIO_W  = 4;
    localparam int ADDR_W  = 24;
    localparam int ID_W    = 5;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        bus_valid = 1'b0;
    logic                        bus_write = 1'b0;
    logic [ADDR_W-1:0]           bus_addr = '0;
    logic [31:0]                 bus_wdata = '0;
    logic [31:0]                 bus_rdata;
    logic                        bus_ready;
    logic [NUM_SRC-1:0]          src_level = '0;
    logic [NUM_SRC*PRIO_W-1:0]   prio_o;
    logic [NUM_CTX*NUM_SRC-1:0]  enable_o;
    logic [NUM_CTX*NUM_SRC-1:0]  pend_set;
    logic [NUM_CTX*NUM_SRC-1:0]  pend_clr;
    logic [NUM_CTX-1:0]          thr_wr;
    logic [NUM_CTX-1:0]          claim_rd;
    logic [NUM_CTX-1:0]          complete_wr;
    logic [31:0]                 ctx_wdata;
    logic [NUM_CTX*PRIO_W-1:0]   arb_thresh   = {4'hA, 4'h5};
    logic [NUM_CTX*ID_W-1:0]     arb_claim_id = {5'd19, 5'd7};

    always #5 clk = ~clk;

    pic_reg_frontend #(
        .NUM_SRC (NUM_SRC), .NUM_CTX (NUM_CTX), .PRIO_W (PRIO_W),
        .ADDR_W (ADDR_W), .ID_W (ID_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_ready (bus_ready), .src_level (src_level), .prio_o (prio_o),
        .enable_o (enable_o), .pend_set (pend_set), .pend_clr (pend_clr),
        .thr_wr (thr_wr), .claim_rd (claim_rd), .complete_wr (complete_wr),
        .ctx_wdata (ctx_wdata), .arb_thresh (arb_thresh), .arb_claim_id (arb_claim_id)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Captured at the ready cycle of the last access.
    logic [31:0] cap_rdata;
    logic        cap_ready;
    logic [63:0] cap_set, cap_clr;
    logic [1:0]  cap_thr, cap_claim, cap_cmp;
    logic [31:0] cap_wdata;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit w, input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        cap_rdata = bus_rdata; cap_ready = bus_ready;
        cap_set = pend_set; cap_clr = pend_clr;
        cap_thr = thr_wr; cap_claim = claim_rd; cap_cmp = complete_wr;
        cap_wdata = ctx_wdata;
    endtask

    // {write, addr, wdata, expected read data}
    localparam int NV = 22;
    localparam logic [88:0] VEC [0:NV-1] = '{
        {1'b1, 24'h000004, 32'hFFFF_FFF3, 32'h0},          // R1 source 1
        {1'b0, 24'h000004, 32'h0,         32'h3},          // R1
        {1'b1, 24'h00007C, 32'h0000_0009, 32'h0},          // R1 source 31
        {1'b0, 24'h00007C, 32'h0,         32'h9},          // R1
        {1'b1, 24'h000000, 32'h0000_000F, 32'h0},          // R2 source 0
        {1'b0, 24'h000000, 32'h0,         32'h0},          // R2
        {1'b1, 24'h000080, 32'h0000_0005, 32'h0},          // R2 source 32
        {1'b0, 24'h000080, 32'h0,         32'h0},          // R2
        {1'b0, 24'h000006, 32'h0,         32'h3},          // R11 low bits on read
        {1'b1, 24'h002000, 32'hFFFF_FFFF, 32'h0},          // R4 ctx0 word0
        {1'b0, 24'h002000, 32'h0,         32'hFFFF_FFFE},  // R4 R3
        {1'b1, 24'h002080, 32'h0000_00F0, 32'h0},          // R3 ctx1
        {1'b0, 24'h002080, 32'h0,         32'h0000_00F0},  // R3
        {1'b0, 24'h002004, 32'h0,         32'h0},          // R10 word past sources
        {1'b1, 24'h002100, 32'h0000_0012, 32'h0},          // R9 ctx2 enable
        {1'b0, 24'h002100, 32'h0,         32'h0},          // R9
        {1'b0, 24'h200000, 32'h0,         32'h5},          // R7 ctx0 threshold
        {1'b0, 24'h201000, 32'h0,         32'hA},          // R7 ctx1 threshold
        {1'b0, 24'h200004, 32'h0,         32'h7},          // R8 ctx0 claim
        {1'b0, 24'h201004, 32'h0,         32'h13},         // R8 ctx1 claim
        {1'b0, 24'h200008, 32'h0,         32'h0},          // R10 reserved offset
        {1'b0, 24'h202000, 32'h0,         32'h0}           // R9 ctx2 control
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check(bus_ready == 1'b0, "R12 ready after reset", 64'(bus_ready), 0);
        check(prio_o == '0, "R12 prio after reset", prio_o[63:0], 0);
        check(enable_o == '0, "R12 enable after reset", enable_o, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][88], VEC[i][87:64], VEC[i][63:32]);
            check(cap_ready == 1'b1, "R12 ready pulse", 64'(cap_ready), 1);
            if (!VEC[i][88])
                check(cap_rdata == VEC[i][31:0], $sformatf("vector %0d read", i),
                      64'(cap_rdata), 64'(VEC[i][31:0]));
        end

        // R12 ready drops after one cycle
        @(negedge clk);
        check(bus_ready == 1'b0, "R12 single ready", 64'(bus_ready), 0);

        // R3 R9 enable state at the ports after the table
        check(enable_o == {32'h0000_00F0, 32'hFFFF_FFFE}, "R3 R9 enable_o", enable_o,
              {32'h0000_00F0, 32'hFFFF_FFFE});
        // R1 priority on the port
        check(prio_o[7:4] == 4'h3, "R1 prio_o source 1", 64'(prio_o[7:4]), 3);
        check(prio_o[3:0] == 4'h0, "R2 prio_o source 0", 64'(prio_o[3:0]), 0);

        // R5 R6 set and clear in one write (level: sources 4,8,9 high)
        src_level = 32'h0000_0310;
        access(1'b1, 24'h002080, 32'h0000_1330);
        check(cap_set == 64'h0000_0300_0000_0000, "R5 pend_set", cap_set, 64'h0000_0300_0000_0000);
        check(cap_clr == 64'h0000_00C0_0000_0000, "R6 pend_clr", cap_clr, 64'h0000_00C0_0000_0000);
        @(negedge clk);
        check(pend_set == '0 && pend_clr == '0, "R5 R6 pulse width", pend_set | pend_clr, 0);
        src_level = '0;

        // R7 threshold write strobe
        access(1'b1, 24'h201000, 32'h0000_003C);
        check(cap_thr == 2'b10 && cap_wdata == 32'h3C, "R7 thr_wr",
              {30'd0, cap_thr, cap_wdata}, {30'd0, 2'b10, 32'h3C});
        // R8 claim read strobe
        access(1'b0, 24'h200004, 32'h0);
        check(cap_claim == 2'b01 && cap_rdata == 32'd7, "R8 claim_rd",
              {30'd0, cap_claim, cap_rdata}, {30'd0, 2'b01, 32'd7});
        // R8 completion write strobe
        access(1'b1, 24'h201004, 32'd19);
        check(cap_cmp == 2'b10 && cap_wdata == 32'd19 && cap_thr == 2'b00, "R8 complete_wr",
              {30'd0, cap_cmp, cap_wdata}, {30'd0, 2'b10, 32'd19});
        // R9 context 2 control write: no strobes
        access(1'b1, 24'h202000, 32'h5);
        check({cap_thr, cap_claim, cap_cmp} == 6'b0, "R9 no strobe",
              64'({cap_thr, cap_claim, cap_cmp}), 0);
        // R10 reserved offset write: no strobes
        access(1'b1, 24'h200008, 32'h5);
        check({cap_thr, cap_claim, cap_cmp} == 6'b0, "R10 no strobe",
              64'({cap_thr, cap_claim, cap_cmp}), 0);
        // R11 low bits on write
        access(1'b1, 24'h00000B, 32'h6);
        access(1'b0, 24'h000008, 32'h0);
        check(cap_rdata == 32'h6, "R11 write low bits", 64'(cap_rdata), 6);

        // R12 reset clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(prio_o == '0 && enable_o == '0 && bus_ready == 1'b0, "R12 reset clears",
              enable_o, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule